// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides one unsigned W-bit integer by another over several clock cycles. A one-cycle start pulse, taken while the block is idle, captures the dividend and divisor. The block then spends one clock per quotient bit. In each of these steps it shifts the partial remainder and the dividend left together and subtracts the divisor as a trial. When the trial goes negative, it adds the divisor back. At the end it presents the quotient and the remainder, and raises a completion strobe for a single cycle.

The partial remainder carries one extra bit so that the sign of each trial difference is visible. A zero divisor does not start any iterations. It completes at once with an error flag, a quotient of all ones and the dividend passed through as the remainder. Results stay on the outputs until the next accepted start, so a consumer can read them at any later time.

Top module: `seqdiv_restore`

## Requirements
- R1: While reset is asserted (active low), and right after it is released, `done`, `div_zero`, `quotient` and `remainder` are all zero.
- R2: A start sampled high while idle with a nonzero divisor loads partial remainder 0 and quotient register = dividend, which appear on `remainder`/`quotient` after that edge. `done` appears after the W-th further rising edge.
- R3: Each iteration shifts {partial remainder, quotient register} left by one and subtracts the divisor from the partial remainder. A negative result gives quotient bit 0 and restores the partial remainder by adding the divisor back. Otherwise the quotient bit is 1 and the difference is kept. For W=4, 7/3 gives (remainder, quotient) after each step of 0/1110, 1/1100, 0/1001, 1/0010, and the partial remainder is never negative between steps.
- R4: With a nonzero divisor, when `done` is high, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor. The remainder is less than the divisor.
- R5: `done` is high for exactly one cycle per accepted operation.
- R6: A zero divisor at an accepted start sets `div_zero`, returns `quotient` all ones and `remainder` = dividend, and raises `done` right after the accepting edge.
- R7: A start pulse that arrives while an operation is running is ignored. The running result and its timing are unchanged.
- R8: While idle and with no start, `quotient`, `remainder` and `div_zero` hold their values even if the operand inputs change.
- R9: An accepted start with a nonzero divisor clears `div_zero`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| dividend | input | W | Unsigned dividend, sampled with start |
| divisor | input | W | Unsigned divisor, sampled with start |
| quotient | output | W | Quotient register (final value when done) |
| remainder | output | W | Partial remainder (final value when done) |
| done | output | 1 | One-cycle completion strobe |
| div_zero | output | 1 | Last accepted operation had a zero divisor |

## Verification
The bound checker captures the operands of every accepted start and checks the following on every cycle:
- the quotient-times-divisor-plus-remainder identity and the remainder bound at each `done`;
- the W-step latency and the immediate zero-divisor completion, using its own cycle counter;
- that the partial remainder is never negative while running;
- the single-cycle strobe;
- that results hold while idle.

Only the bench scenarios can show the intermediate shift-and-restore trace of a known division and the reset values. The same applies to discarding a start that arrives mid-operation and to clearing the zero flag on the next valid operation. The bench covers both widths: every operand pair at W=4 and corner plus random pairs at W=8.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } seqdiv_phase_e;
endpackage

// File: rtl/seqdiv_iter.sv
// One restoring step: shift pair left, trial subtract, add back on negative.
module seqdiv_iter #(
    parameter int W = 8
) (
    input  logic [W:0]   a_i,
    input  logic [W-1:0] q_i,
    input  logic [W-1:0] m_i,
    output logic [W:0]   a_o,
    output logic [W-1:0] q_o
);
    logic [W:0] a_sh;
    logic [W:0] trial;
    logic [W:0] addback;
    logic       neg;

    always_comb begin
        a_sh    = {a_i[W-1:0], q_i[W-1]};
        trial   = a_sh - {1'b0, m_i};
        neg     = trial[W];
        addback = trial + {1'b0, m_i};
        a_o     = neg ? addback : trial;
        q_o     = {q_i[W-2:0], ~neg};
    end
endmodule

// File: rtl/seqdiv_pace.sv
// Iteration counter: flags the final step of a run.
module seqdiv_pace #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    output logic last
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = '0;
        else if (step)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign last = (cnt_q == LAST_IDX);
endmodule

// File: rtl/seqdiv_restore.sv
module seqdiv_restore #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         done,
    output logic         div_zero
);
    import seqdiv_pkg::*;

    typedef struct packed {
        logic [W:0]    a;
        logic [W-1:0]  q;
        logic [W-1:0]  m;
        seqdiv_phase_e ph;
        logic          done;
        logic          dz;
    } st_t;

    st_t st_d, st_q;

    logic         running;
    logic         accept;
    logic         last;
    logic [W:0]   a_nx;
    logic [W-1:0] q_nx;

    assign running = (st_q.ph == PH_RUN);
    assign accept  = start && !running;

    seqdiv_iter #(.W(W)) u_iter (
        .a_i (st_q.a),
        .q_i (st_q.q),
        .m_i (st_q.m),
        .a_o (a_nx),
        .q_o (q_nx)
    );

    seqdiv_pace #(.W(W)) u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .step  (running),
        .last  (last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            if (divisor == '0) begin
                st_d.a    = {1'b0, dividend};
                st_d.q    = '1;
                st_d.m    = '0;
                st_d.dz   = 1'b1;
                st_d.done = 1'b1;
                st_d.ph   = PH_IDLE;
            end else begin
                st_d.a  = '0;
                st_d.q  = dividend;
                st_d.m  = divisor;
                st_d.dz = 1'b0;
                st_d.ph = PH_RUN;
            end
        end else if (running) begin
            st_d.a = a_nx;
            st_d.q = q_nx;
            if (last) begin
                st_d.ph   = PH_IDLE;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{a: '0, q: '0, m: '0, ph: PH_IDLE, done: 1'b0, dz: 1'b0};
        else
            st_q <= st_d;
    end

    assign quotient  = st_q.q;
    assign remainder = st_q.a[W-1:0];
    assign done      = st_q.done;
    assign div_zero  = st_q.dz;
endmodule

// File: rtl/seqdiv_restore_chk.sv
module seqdiv_restore_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         done,
    input logic         div_zero,
    input logic         busy,
    input logic         a_msb
);
    localparam int SAT = W + 4;

    logic [W-1:0]   cap_a, cap_b;
    int unsigned    since;
    logic [2*W-1:0] recon;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_a <= '0;
            cap_b <= '0;
            since <= SAT;
        end else if (start && !busy) begin
            cap_a <= dividend;
            cap_b <= divisor;
            since <= 0;
        end else if (since < SAT) begin
            since <= since + 1;
        end
    end

    assign recon = {{W{1'b0}}, quotient} * {{W{1'b0}}, cap_b} + {{W{1'b0}}, remainder};

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero) |-> (since == W));

    p_no_negative_rem_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !a_msb);

    p_quotient_identity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero) |-> ((recon == {{W{1'b0}}, cap_a}) && (remainder < cap_b)));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_zero_divisor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> ((quotient == '1) && (remainder == cap_a) && (since == 0)));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));
endmodule

bind seqdiv_restore seqdiv_restore_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder),
    .done      (done),
    .div_zero  (div_zero),
    .busy      (running),
    .a_msb     (st_q.a[W])
);

// File: tb/seqdiv_restore_test.sv
module seqdiv_restore_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n;
    logic       st4, st8;
    logic [3:0] a4, b4, q4, r4;
    logic [7:0] a8, b8, q8, r8;
    logic       d4, z4, d8, z8;

    int total = 0;
    int bad   = 0;

    seqdiv_restore #(.W(4)) uut (
        .clk(clk), .rst_n(rst_n), .start(st4), .dividend(a4), .divisor(b4),
        .quotient(q4), .remainder(r4), .done(d4), .div_zero(z4));

    seqdiv_restore #(.W(8)) uut_w8 (
        .clk(clk), .rst_n(rst_n), .start(st8), .dividend(a8), .divisor(b8),
        .quotient(q8), .remainder(r8), .done(d8), .div_zero(z8));

    task automatic check_eq(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] get_q(input bit wide);
        return wide ? q8 : {4'b0, q4};
    endfunction
    function automatic logic [7:0] get_r(input bit wide);
        return wide ? r8 : {4'b0, r4};
    endfunction

    task automatic issue(input bit wide, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        if (wide) begin st8 = 1'b1; a8 = a; b8 = b; end
        else begin st4 = 1'b1; a4 = a[3:0]; b4 = b[3:0]; end
        @(negedge clk);
        st4 = 1'b0;
        st8 = 1'b0;
    endtask

    task automatic wait_done(input bit wide, inout int lat);
        while (!(wide ? d8 : d4) && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // one full operation with all result checks
    task automatic one_div(input bit wide, input logic [7:0] a, input logic [7:0] b);
        int n, lat, eq, er;
        n   = wide ? 8 : 4;
        lat = 1;
        issue(wide, a, b);
        wait_done(wide, lat);
        if (b == 0) begin
            eq = (1 << n) - 1;
            er = a;
            check_eq("R6 latency", lat, 1);
            check_eq("R6 quotient", get_q(wide), eq);
            check_eq("R6 remainder", get_r(wide), er);
            check_eq("R6 div_zero", wide ? z8 : z4, 1);
        end else begin
            eq = a / b;
            er = a % b;
            check_eq("R2 latency", lat, n + 1);
            check_eq("R4 quotient", get_q(wide), eq);
            check_eq("R4 remainder", get_r(wide), er);
            check_eq("R9 div_zero clear", wide ? z8 : z4, 0);
        end
        @(negedge clk);
        check_eq("R5 done one cycle", wide ? d8 : d4, 0);
    endtask

    task automatic t_reset();
        check_eq("R1 done", d8, 0);
        check_eq("R1 div_zero", z8, 0);
        check_eq("R1 quotient", q8, 0);
        check_eq("R1 remainder", r8, 0);
        check_eq("R1 done w4", d4, 0);
    endtask

    // 7/3 at W=4: load then four shift/trial/restore steps
    task automatic t_trace_r3();
        issue(1'b0, 8'd7, 8'd3);
        check_eq("R2 load quotient", q4, 7);
        check_eq("R2 load remainder", r4, 0);
        @(negedge clk);
        check_eq("R3 step1 rem", r4, 0);
        check_eq("R3 step1 q", q4, 4'b1110);
        @(negedge clk);
        check_eq("R3 step2 rem", r4, 1);
        check_eq("R3 step2 q", q4, 4'b1100);
        @(negedge clk);
        check_eq("R3 step3 rem", r4, 0);
        check_eq("R3 step3 q", q4, 4'b1001);
        @(negedge clk);
        check_eq("R3 step4 rem", r4, 1);
        check_eq("R3 step4 q", q4, 4'b0010);
        check_eq("R3 done", d4, 1);
        @(negedge clk);
    endtask

    task automatic t_exhaustive_w4();
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                one_div(1'b0, 8'(a), 8'(b));
    endtask

    task automatic t_sample_w8();
        one_div(1'b1, 8'd255, 8'd1);
        one_div(1'b1, 8'd255, 8'd255);
        one_div(1'b1, 8'd0, 8'd5);
        one_div(1'b1, 8'd1, 8'd255);
        one_div(1'b1, 8'd254, 8'd127);
        one_div(1'b1, 8'd128, 8'd0);
        one_div(1'b1, 8'd200, 8'd13);
        for (int i = 0; i < 200; i++) begin
            logic [7:0] ra, rb;
            ra = 8'($urandom);
            rb = 8'($urandom);
            one_div(1'b1, ra, rb);
        end
    endtask

    // R7: start during a run must be discarded
    task automatic t_busy_start();
        int lat;
        lat = 1;
        issue(1'b1, 8'd200, 8'd7);
        repeat (3) begin @(negedge clk); lat++; end
        st8 = 1'b1; a8 = 8'd9; b8 = 8'd3;
        @(negedge clk);
        st8 = 1'b0;
        lat++;
        wait_done(1'b1, lat);
        check_eq("R7 latency kept", lat, 9);
        check_eq("R7 quotient kept", q8, 28);
        check_eq("R7 remainder kept", r8, 4);
        @(negedge clk);
    endtask

    // R8: results hold while inputs wander without start
    task automatic t_hold();
        one_div(1'b1, 8'd100, 8'd9);
        for (int i = 0; i < 5; i++) begin
            a8 = 8'(i * 37 + 1);
            b8 = 8'(i);
            @(negedge clk);
        end
        check_eq("R8 quotient held", q8, 11);
        check_eq("R8 remainder held", r8, 1);
        check_eq("R8 div_zero held", z8, 0);
        one_div(1'b1, 8'd77, 8'd0);
        a8 = 8'd3; b8 = 8'd1;
        repeat (4) @(negedge clk);
        check_eq("R8 zero flag held", z8, 1);
        check_eq("R8 zero quotient held", q8, 255);
        check_eq("R8 zero remainder held", r8, 77);
        one_div(1'b1, 8'd50, 8'd6);
        check_eq("R9 flag cleared", z8, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        st4 = 1'b0; st8 = 1'b0;
        a4 = '0; b4 = '0; a8 = '0; b8 = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_trace_r3();
        t_exhaustive_w4();
        t_sample_w8();
        t_busy_start();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule